// File: doc/BRIEF.md
# Rollover Timer with Shared Prescaler and Watchdog

This block is an 8-bit free-running event counter for a small processor subsystem. It advances either on the core's instruction-cycle enable or on a chosen edge of an external input pin. The external pin is synchronized before its edges are detected. A single power-of-two prescaler sits in front of either the event counter or the watchdog. The other consumer then runs undivided.

An 8-bit control word sets the count source, the active pin edge, where the prescaler goes, the divide code and whether a rollover raises an interrupt. Software can also write the counter. Preloading it with 256-N shortens the next rollover period to N counts. For example, a 4 MHz cycle enable, a divide of 128 and a period of 156 counts give about 200 interrupts each second.

A synthesis parameter can freeze the top two control bits at one. The watchdog counts on its own, times out when it wraps, and is restarted by a clear strobe from the core.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter reads 0x00, the control word reads 0xFF (rollover interrupt off), and `irq` and `wdt_timeout` are low.
- R2: A control-word write takes effect on the next clock. With FREEZE_HI=0 all eight bits read back as written. The fields are: bit 7 a stored flag with no timer function, bit 6 interrupt disable, bit 5 source select (1 = pin), bit 4 edge select (1 = falling), bit 3 prescaler assignment (1 = watchdog), bits 2..0 divide code.
- R3: With bit 5 = 0 and bit 3 = 1, the counter rises by exactly one on each clock where `cyc_en` is high, and stays the same otherwise.
- R4: With bit 3 = 0, the counter advances once every 2^(code+1) source events, where code is bits 2..0, so the ratios run from 1:2 to 1:256.
- R5: With bit 5 = 1, the source events are edges of `ext_pin` after a two-flop synchronizer: rising edges when bit 4 = 0, falling edges when bit 4 = 1. An edge present before clock k moves the counter at clock k+2.
- R6: When a count step takes the counter from 0xFF to 0x00 and bit 6 is 0, `irq` is high for exactly the one cycle in which the counter reads 0x00. When bit 6 is 1, `irq` stays low.
- R7: A counter write loads `cnt_wdata` on the next clock. It takes priority over a count step in the same cycle, and that step produces no interrupt.
- R8: A control-word write clears the prescaler's running count, so the next divided event comes a full ratio later.
- R9: The watchdog counts `cyc_en` pulses. With bit 3 = 1 it counts them divided by 2^code (1:1 to 1:128), and with bit 3 = 0 it counts them undivided. It raises `wdt_timeout` for one cycle each time its 8-bit count wraps. `wdt_clr` restarts its count and, when the prescaler is assigned to it, also the prescaler.
- R10: With FREEZE_HI=1, control bits 7 and 6 always read as one, so the rollover interrupt can never be enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| ext_pin | input | 1 | Asynchronous external count input |
| opt_wr | input | 1 | Control-word write strobe |
| opt_wdata | input | 8 | Control-word write data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| wdt_clr | input | 1 | Watchdog restart strobe |
| irq | output | 1 | Rollover interrupt pulse |
| wdt_timeout | output | 1 | Watchdog timeout pulse |
| cnt_q | output | 8 | Counter value |
| opt_q | output | 8 | Control word readback |

## Verification
The hardest case to reach from the ports is a rollover that lands exactly while a prescaled count is in flight and a control-word write or a counter write arrives. Reaching it through free running would take hundreds of divided events. The stimulus therefore preloads the counter close to 0xFF with a counter write. It then rewrites the control word at irregular points and drives `cyc_en` from a pseudo-random pattern, so that rollovers, prescaler clears and load-over-step collisions fall into a few hundred cycles. A behavioural model predicts every output on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   localparam int CTRL_W = 8;

   // Control word fields; the bit positions are software visible
   typedef struct packed {
      logic       regsel;      // stored only, no timer function
      logic       irq_off;     // 1 = rollover interrupt masked
      logic       src_ext;     // 1 = count external pin edges
      logic       fall_edge;   // 1 = falling pin edges
      logic       pre_to_wdt;  // 1 = prescaler drives the watchdog
      logic [2:0] ratio;       // divide code
   } ctrl_t;

   localparam logic [CTRL_W-1:0] CTRL_RESET = 8'hFF;

endpackage

// File: rtl/tick_sync_edge.sv
module tick_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_hit
);
   localparam int LAST = STAGES;

   // chain[0..STAGES-1] are synchronizer flops, chain[LAST] holds the previous value
   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tick_sync_edge: STAGES must be at least 2");
      end
      for (genvar s = 0; s <= LAST; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   logic now_v;
   logic was_v;
   assign now_v = chain[LAST-1];
   assign was_v = chain[LAST];

   always_comb begin
      if (fall_sel) edge_hit = was_v & ~now_v;
      else          edge_hit = now_v & ~was_v;
   end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int PS_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 step,
   input  logic [PS_W-1:0]      code,
   input  logic                 to_wdt,
   output logic                 hit,
   output logic [(1<<PS_W)-1:0] pre_cnt
);
   localparam int PRE_W = 1 << PS_W;

   logic [PRE_W-1:0] mask;

   // Watchdog side divides by 2^code, counter side by 2^(code+1)
   generate
      if (PS_W < 1 || PS_W > 5) begin : g_bad_ps
         $error("tick_prescaler: PS_W out of range");
      end
      for (genvar i = 0; i < PRE_W; i++) begin : g_mask
         always_comb begin
            if (to_wdt) mask[i] = (code >  PS_W'(i));
            else        mask[i] = (code >= PS_W'(i));
         end
      end
   endgenerate

   assign hit = step && ((pre_cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pre_cnt <= '0;
      else if (clr)   pre_cnt <= '0;
      else if (step)  pre_cnt <= pre_cnt + 1'b1;
   end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("tick_counter: CNT_W must be at least 2");
      end
   endgenerate

   // Rollover only from a real step, never from a load
   assign wrap = step & ~load & (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (step)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
   parameter int WDT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic timeout
);
   logic [WDT_W-1:0] wcnt;
   logic             wrap_now;

   generate
      if (WDT_W < 2) begin : g_bad_w
         $error("tick_watchdog: WDT_W must be at least 2");
      end
   endgenerate

   assign wrap_now = step & ~clr & (&wcnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt    <= '0;
         timeout <= 1'b0;
      end else begin
         timeout <= wrap_now;
         if (clr)       wcnt <= '0;
         else if (step) wcnt <= wcnt + 1'b1;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PS_W        = 3,
   parameter int WDT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit FREEZE_HI   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              ext_pin,
   input  logic              opt_wr,
   input  logic [CTRL_W-1:0] opt_wdata,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              wdt_clr,
   output logic              irq,
   output logic              wdt_timeout,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CTRL_W-1:0] opt_q
);
   localparam int PRE_W = 1 << PS_W;

   generate
      if (PS_W != 3) begin : g_bad_code
         $error("tick_timer: the control word holds a 3-bit divide code");
      end
   endgenerate

   // Control word storage; the top two bits are optional
   logic [5:0] ctrl_lo;
   logic [1:0] ctrl_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_lo <= CTRL_RESET[5:0];
      else if (opt_wr) ctrl_lo <= opt_wdata[5:0];
   end

   generate
      if (FREEZE_HI) begin : g_hi_fixed
         assign ctrl_hi = 2'b11;
      end else begin : g_hi_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ctrl_hi <= CTRL_RESET[7:6];
            else if (opt_wr) ctrl_hi <= opt_wdata[7:6];
         end
      end
   endgenerate

   ctrl_t ctrl;
   assign opt_q = {ctrl_hi, ctrl_lo};
   assign ctrl  = ctrl_t'(opt_q);

   // Source selection
   logic pin_edge;
   logic src_evt;

   tick_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (ctrl.fall_edge),
      .edge_hit (pin_edge)
   );

   assign src_evt = ctrl.src_ext ? pin_edge : cyc_en;

   // Shared prescaler
   logic             pre_step;
   logic             pre_hit;
   logic             pre_clr;
   logic [PRE_W-1:0] pre_cnt;

   assign pre_step = ctrl.pre_to_wdt ? cyc_en : src_evt;
   assign pre_clr  = opt_wr | (wdt_clr & ctrl.pre_to_wdt);

   tick_prescaler #(.PS_W(PS_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pre_clr),
      .step    (pre_step),
      .code    (ctrl.ratio),
      .to_wdt  (ctrl.pre_to_wdt),
      .hit     (pre_hit),
      .pre_cnt (pre_cnt)
   );

   // Event counter
   logic cnt_step;
   logic cnt_wrap;

   assign cnt_step = ctrl.pre_to_wdt ? src_evt : pre_hit;

   tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_wr),
      .load_val (cnt_wdata),
      .step     (cnt_step),
      .cnt      (cnt_q),
      .wrap     (cnt_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= cnt_wrap & ~ctrl.irq_off;
   end

   // Watchdog
   logic wdt_step;
   assign wdt_step = ctrl.pre_to_wdt ? pre_hit : cyc_en;

   tick_watchdog #(.WDT_W(WDT_W)) u_wdt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (wdt_clr),
      .step    (wdt_step),
      .timeout (wdt_timeout)
   );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W     = 8,
   parameter int PS_W      = 3,
   parameter bit FREEZE_HI = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cnt_wr,
   input logic [CNT_W-1:0]     cnt_wdata,
   input logic                 opt_wr,
   input logic [7:0]           opt_wdata,
   input logic                 irq,
   input logic                 wdt_timeout,
   input logic [CNT_W-1:0]     cnt_q,
   input logic [7:0]           opt_q,
   input logic [(1<<PS_W)-1:0] pre_cnt
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      irq |=> !irq); // R6
   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      irq |-> (cnt_q == '0)); // R6
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      irq |-> !$past(opt_q[6])); // R6
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (!$past(cnt_wr) && cnt_q != $past(cnt_q)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      $past(cnt_wr) |-> (cnt_q == $past(cnt_wdata))); // R7
   AST_CTRL_LO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      $past(opt_wr) |-> (opt_q[5:0] == $past(opt_wdata[5:0]))); // R2
   AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      $past(opt_wr) |-> (pre_cnt == '0)); // R8
   AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      wdt_timeout |=> !wdt_timeout); // R9

   generate
      if (FREEZE_HI) begin : g_frozen
         AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (opt_q[7:6] == 2'b11) && !irq); // R10
      end else begin : g_open
         AST_CTRL_HI: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $past(opt_wr) |-> (opt_q[7:6] == $past(opt_wdata[7:6]))); // R2
      end
   endgenerate
endmodule

bind tick_timer tick_timer_chk #(
   .CNT_W     (CNT_W),
   .PS_W      (PS_W),
   .FREEZE_HI (FREEZE_HI)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt_wr      (cnt_wr),
   .cnt_wdata   (cnt_wdata),
   .opt_wr      (opt_wr),
   .opt_wdata   (opt_wdata),
   .irq         (irq),
   .wdt_timeout (wdt_timeout),
   .cnt_q       (cnt_q),
   .opt_q       (opt_q),
   .pre_cnt     (pre_cnt)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b1;
   logic       ext_pin = 1'b0;
   logic       opt_wr = 1'b0;
   logic [7:0] opt_wdata = 8'h00;
   logic       cnt_wr = 1'b0;
   logic [7:0] cnt_wdata = 8'h00;
   logic       wdt_clr = 1'b0;

   logic       irq_a, to_a, irq_b, to_b;
   logic [7:0] cnt_a, opt_a, cnt_b, opt_b;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
      .opt_wr(opt_wr), .opt_wdata(opt_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .wdt_clr(wdt_clr), .irq(irq_a), .wdt_timeout(to_a), .cnt_q(cnt_a), .opt_q(opt_a)
   );

   tick_timer #(.FREEZE_HI(1'b1)) u_tick_timer_frozen (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
      .opt_wr(opt_wr), .opt_wdata(opt_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .wdt_clr(wdt_clr), .irq(irq_b), .wdt_timeout(to_b), .cnt_q(cnt_b), .opt_q(opt_b)
   );

   int    total = 0;
   int    bad = 0;
   string phase = "R1 reset";

   task automatic check(input int actual, input int expected, input string what);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, actual, expected);
      end
   endtask

   // Behavioural reference: index 0 = open control word, 1 = frozen high bits
   int m_cnt[2], m_pre[2], m_wdt[2], m_opt[2], m_irq[2], m_to[2];
   int p1, p2, p3;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_cnt[k] = 0; m_pre[k] = 0; m_wdt[k] = 0;
            m_opt[k] = 255; m_irq[k] = 0; m_to[k] = 0;
         end
         p1 = 0; p2 = 0; p3 = 0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            int o, div_wdt, code, src, ev, step, limit, pre_evt, c_step, w_step, roll, to_n;
            o       = (k == 1) ? (m_opt[k] | 8'hC0) : m_opt[k];
            div_wdt = (o >> 3) & 1;
            code    = o & 7;
            if (((o >> 4) & 1) == 1) ev = (p3 == 1 && p2 == 0) ? 1 : 0;
            else                     ev = (p2 == 1 && p3 == 0) ? 1 : 0;
            src     = (((o >> 5) & 1) == 1) ? ev : int'(cyc_en);
            step    = div_wdt ? int'(cyc_en) : src;
            limit   = div_wdt ? (1 << code) : (1 << (code + 1));
            pre_evt = (step == 1 && (m_pre[k] % limit) == limit - 1) ? 1 : 0;
            c_step  = div_wdt ? src : pre_evt;
            w_step  = div_wdt ? pre_evt : int'(cyc_en);
            roll    = (!cnt_wr && c_step == 1 && m_cnt[k] == 255) ? 1 : 0;
            m_irq[k] = (roll == 1 && ((o >> 6) & 1) == 0) ? 1 : 0;
            to_n = 0;
            if (wdt_clr) m_wdt[k] = 0;
            else if (w_step == 1) begin
               if (m_wdt[k] == 255) to_n = 1;
               m_wdt[k] = (m_wdt[k] + 1) % 256;
            end
            m_to[k] = to_n;
            if (opt_wr || (wdt_clr && div_wdt == 1)) m_pre[k] = 0;
            else if (step == 1) m_pre[k] = (m_pre[k] + 1) % 256;
            if (cnt_wr) m_cnt[k] = cnt_wdata;
            else if (c_step == 1) m_cnt[k] = (m_cnt[k] + 1) % 256;
            if (opt_wr) m_opt[k] = opt_wdata;
         end
         p3 = p2; p2 = p1; p1 = ext_pin;
      end
   end

   // Every-clock comparison, away from the active edge
   logic compare_on = 1'b0;
   always @(negedge clk) begin
      if (compare_on && rst_n) begin
         check(cnt_a, m_cnt[0], "cnt_q");
         check(opt_a, m_opt[0], "opt_q");
         check(irq_a, m_irq[0], "irq");
         check(to_a,  m_to[0],  "wdt_timeout");
         check(cnt_b, m_cnt[1], "frozen cnt_q (R10)");
         check(opt_b, m_opt[1] | 8'hC0, "frozen opt_q (R10)");
         check(irq_b, m_irq[1], "frozen irq (R10)");
         check(to_b,  m_to[1],  "frozen wdt_timeout");
      end
   end

   // Input pattern generators
   int          cyc_mode = 0;
   int          pin_period = 0;
   int          pin_ctr = 0;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc_en <= (cyc_mode == 0) ? 1'b1 : lfsr[3];
      if (pin_period > 0) begin
         if (pin_ctr >= pin_period - 1) begin
            pin_ctr <= 0;
            ext_pin <= ~ext_pin;
         end else pin_ctr <= pin_ctr + 1;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_ctrl(input logic [7:0] v);
      @(negedge clk);
      opt_wr = 1'b1; opt_wdata = v;
      @(negedge clk);
      opt_wr = 1'b0;
   endtask

   task automatic put_cnt(input logic [7:0] v);
      @(negedge clk);
      cnt_wr = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_wr = 1'b0;
   endtask

   task automatic kick;
      @(negedge clk);
      wdt_clr = 1'b1;
      @(negedge clk);
      wdt_clr = 1'b0;
   endtask

   // Watchdog
   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired in phase %s: actual=hung expected=done", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(4);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cnt_a, 0, "R1 counter after reset");
      check(opt_a, 255, "R1 control word after reset");
      check(irq_a, 0, "R1 irq after reset");
      check(to_a, 0, "R1 timeout after reset");
      compare_on = 1'b1;

      phase = "R2 R3 full-speed count";
      put_ctrl(8'h08);
      check(opt_a, 8'h08, "R2 readback");
      check(opt_b, 8'hC8, "R10 frozen readback");
      idle(300);

      phase = "R7 R6 preload timing";
      begin
         int n;
         put_cnt(8'd200);
         n = 0;
         while (!irq_a && n < 400) begin
            @(negedge clk);
            n++;
         end
         check(n, 56, "R7 cycles from preload to irq");
         check(irq_b, 0, "R10 frozen block gives no irq");
      end

      phase = "R3 sparse cycle enable";
      cyc_mode = 1;
      idle(600);

      phase = "R4 prescaled ratios";
      cyc_mode = 0;
      for (int c = 0; c < 3; c++) begin
         put_ctrl(8'(c));
         put_cnt(8'd240);
         idle(150);
      end
      cyc_mode = 1;
      put_ctrl(8'h01);
      idle(400);

      phase = "R8 control rewrite clears prescaler";
      cyc_mode = 0;
      put_ctrl(8'h02);
      put_cnt(8'd254);
      for (int i = 0; i < 12; i++) begin
         idle(5);
         put_ctrl(8'h02);
      end
      idle(40);

      phase = "R7 load over step";
      put_ctrl(8'h08);
      put_cnt(8'hFF);
      put_cnt(8'hFF);
      put_cnt(8'h10);
      idle(10);

      phase = "R6 masked rollover";
      put_ctrl(8'h48);
      put_cnt(8'd250);
      idle(20);

      phase = "R5 rising pin edges";
      pin_period = 3;
      put_ctrl(8'h28);
      put_cnt(8'd245);
      idle(200);

      phase = "R5 falling pin edges prescaled";
      pin_period = 2;
      put_ctrl(8'h30);
      put_cnt(8'd250);
      idle(200);
      pin_period = 0;

      phase = "R9 watchdog divided and kicked";
      cyc_mode = 0;
      put_ctrl(8'h08);
      kick();
      idle(600);
      put_ctrl(8'h09);
      kick();
      idle(700);
      put_ctrl(8'h00);
      for (int i = 0; i < 6; i++) begin
         idle(100);
         kick();
         check(to_a, 0, "R9 timeout stays low while kicked");
      end
      cyc_mode = 1;
      put_ctrl(8'h0A);
      idle(1500);

      compare_on = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule